// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block stands between a peripheral bus and a small group of special control registers whose writes must not happen by accident. Software unlocks a single write by first writing a command register; the very next peripheral write may then land in a special register. The block watches the bus strobes and addresses, raises a one-hot write enable for the addressed special register only when that ordering holds, and records any broken ordering in a sticky error flag held in a readable 8-bit status register.

A two-state machine tracks the sequence. In state `SEQ_IDLE` a command-register write takes transition `ARM` to state `SEQ_ARMED`; any other peripheral write stays in `SEQ_IDLE` (transition `HOLD`), and if it targets a special register it is blocked and flagged. In `SEQ_ARMED` the next peripheral write of any kind takes transition `CONSUME` back to `SEQ_IDLE`: a special-register write is let through, anything else (including a second command write) is flagged. Peripheral reads and internal RAM accesses cause no transition. Software clears the flag by writing 0 to it; a clear wins over an error raised in the same cycle.

Top module: `prot_wr_seq`

## Requirements
- R1: After reset `perr` is 0, the state is idle, and a read of the status address returns 8'h00.
- R2: A peripheral write to special register k directly after a command-register write drives `spec_we` with only bit k set, combinationally in the strobe cycle, and leaves `perr` unchanged.
- R3: A peripheral write to a special register with no command write directly before it keeps `spec_we` at 0 and sets `perr` from the following clock edge.
- R4: After a command write, a peripheral write (byte or single-bit) to a non-special, non-status address sets `perr`, and a following special write is blocked.
- R5: Two command writes in a row set `perr`, and the sequence is then consumed: the next special write is blocked.
- R6: Peripheral reads (`bus_rd`) and any access with `bus_ram` high, placed between the command write and the special write, neither disarm the sequence nor set `perr`.
- R7: Each command write enables at most one special write; a second special write right after an enabled one is blocked and sets `perr`.
- R8: A read at the status address returns {7'b0, perr} on `rd_data`; a read at any other address returns 8'h00.
- R9: `perr` clears on a byte write to the status address with data bit 0 at 0, or on a single-bit write (`bus_bitop` high) with `bus_bitpos`=0 and `bus_wdata[bus_bitpos]`=0. Writing 1, or a single-bit write to bits 1..7, leaves `perr` unchanged.
- R10: A status write of 0 directly after a command write leaves `perr` at 0 even though the sequence was broken; a status write of 1 there leaves `perr` at 1.
- R11: A write with `bus_ram` high, even to a special-register address, raises no `spec_we` and does not set `perr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_ram | input | 1 | Access targets internal RAM, not a peripheral register |
| bus_bitop | input | 1 | Write is a single-bit (read-modify-write) operation |
| bus_bitpos | input | 3 | Bit position for a single-bit write |
| bus_addr | input | AW | Access address |
| bus_wdata | input | 8 | Write data; for a single-bit write the value is in lane `bus_bitpos` |
| spec_we | output | NUM_SPEC | One-hot write enable for the special registers |
| perr | output | 1 | Sticky protection-error flag |
| rd_data | output | 8 | Status read data, 0 unless the status address is read |

## Verification
The hardest situation to reach is the cycle where an explicit clear of the flag and a newly detected sequence error coincide, since it needs the flag already set, an armed sequence, and then a status write as the consuming access. The stimulus first provokes an unprotected special write to set the flag, arms with a command write, then writes 0 to the status register, and repeats this with a 1 to show the error side. Reads and RAM accesses are also interleaved inside an armed window to show the armed state survives them.

// File: rtl/prot_wr_seq_pkg.sv
package prot_wr_seq_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic is_cmd;
        logic is_stat;
        logic is_spec;
    } addr_class_t;

endpackage

// File: rtl/prot_wr_seq_decode.sv
module prot_wr_seq_decode
    import prot_wr_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int NUM_SPEC = 3,
    parameter logic [AW-1:0] CMD_ADDR = 12'h0F0,
    parameter logic [AW-1:0] STAT_ADDR = 12'h0F2,
    parameter logic [NUM_SPEC*AW-1:0] SPEC_ADDRS = {12'h0AC, 12'h0A8, 12'h0A4}
) (
    input  logic [AW-1:0]       addr,
    output logic [NUM_SPEC-1:0] spec_hit,
    output addr_class_t         cls
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SPEC; gi++) begin : g_spec_cmp
            assign spec_hit[gi] = (addr == SPEC_ADDRS[gi*AW +: AW]);
        end
    endgenerate

    always_comb begin
        cls.is_cmd  = (addr == CMD_ADDR);
        cls.is_stat = (addr == STAT_ADDR);
        cls.is_spec = |spec_hit;
    end

endmodule

// File: rtl/prot_wr_seq_fsm.sv
module prot_wr_seq_fsm
    import prot_wr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic per_wr,
    input  logic is_cmd,
    input  logic is_spec,
    output logic armed,
    output logic allow_spec,
    output logic err_set
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (per_wr && is_cmd) state_d = SEQ_ARMED;
            SEQ_ARMED: if (per_wr)           state_d = SEQ_IDLE;
            default:                         state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        armed      = (state_q == SEQ_ARMED);
        allow_spec = 1'b0;
        err_set    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                err_set = per_wr && is_spec;
            end
            SEQ_ARMED: begin
                allow_spec = per_wr && is_spec;
                err_set    = per_wr && !is_spec;
            end
            default: begin
                allow_spec = 1'b0;
                err_set    = 1'b0;
            end
        endcase
    end

    // R7: a write while armed always returns the sequence to idle
    assert_armed_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && per_wr) |=> !armed);

    // R6: no peripheral write means no state change
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr |=> $stable(armed));

endmodule

// File: rtl/prot_wr_seq_status.sv
module prot_wr_seq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_wr,
    input  logic       stat_rd,
    input  logic       bitop,
    input  logic [2:0] bitpos,
    input  logic [7:0] wdata,
    input  logic       err_set,
    output logic       perr,
    output logic [7:0] rd_data
);

    logic lane_val;
    logic clr_req;

    always_comb begin
        lane_val = bitop ? wdata[bitpos] : wdata[0];
        clr_req  = stat_wr && (!bitop || (bitpos == 3'd0)) && !lane_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       perr <= 1'b0;
        else if (clr_req) perr <= 1'b0;
        else if (err_set) perr <= 1'b1;
    end

    always_comb begin
        rd_data = stat_rd ? {7'b0, perr} : 8'h00;
    end

    // R10: an explicit clear wins over a simultaneous error
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !perr);

    // R9: the flag only rises when hardware reports an error
    assert_rise_needs_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr && !err_set) |=> !perr);

    // R8: upper status bits always read as zero
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:1] == 7'b0);

endmodule

// File: rtl/prot_wr_seq.sv
module prot_wr_seq
    import prot_wr_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int NUM_SPEC = 3,
    parameter logic [AW-1:0] CMD_ADDR = 12'h0F0,
    parameter logic [AW-1:0] STAT_ADDR = 12'h0F2,
    parameter logic [NUM_SPEC*AW-1:0] SPEC_ADDRS = {12'h0AC, 12'h0A8, 12'h0A4}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic                bus_ram,
    input  logic                bus_bitop,
    input  logic [2:0]          bus_bitpos,
    input  logic [AW-1:0]       bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [NUM_SPEC-1:0] spec_we,
    output logic                perr,
    output logic [7:0]          rd_data
);

    logic [NUM_SPEC-1:0] spec_hit;
    addr_class_t         cls;
    logic                per_wr;
    logic                per_rd;
    logic                armed;
    logic                allow_spec;
    logic                err_set;

    assign per_wr = bus_wr && !bus_ram;
    assign per_rd = bus_rd && !bus_wr && !bus_ram;

    prot_wr_seq_decode #(
        .AW(AW), .NUM_SPEC(NUM_SPEC), .CMD_ADDR(CMD_ADDR),
        .STAT_ADDR(STAT_ADDR), .SPEC_ADDRS(SPEC_ADDRS)
    ) u_decode (
        .addr     (bus_addr),
        .spec_hit (spec_hit),
        .cls      (cls)
    );

    prot_wr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_wr     (per_wr),
        .is_cmd     (cls.is_cmd),
        .is_spec    (cls.is_spec),
        .armed      (armed),
        .allow_spec (allow_spec),
        .err_set    (err_set)
    );

    prot_wr_seq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (per_wr && cls.is_stat),
        .stat_rd (per_rd && cls.is_stat),
        .bitop   (bus_bitop),
        .bitpos  (bus_bitpos),
        .wdata   (bus_wdata),
        .err_set (err_set),
        .perr    (perr),
        .rd_data (rd_data)
    );

    assign spec_we = spec_hit & {NUM_SPEC{allow_spec}};

    // R2: never more than one special register enabled
    assert_we_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spec_we));

    // R3: an enable needs the sequence armed
    assert_we_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|spec_we) |-> armed);

    // R7: two enables can never occur back to back
    assert_single_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|spec_we) |=> !(|spec_we));

    // R11: RAM accesses never produce an enable
    assert_ram_no_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ram |-> (spec_we == '0));

endmodule

// File: tb/tb_prot_wr_seq.sv
module tb_prot_wr_seq;

    localparam logic [11:0] A_CMD  = 12'h0F0;
    localparam logic [11:0] A_STAT = 12'h0F2;
    localparam logic [11:0] A_S0   = 12'h0A4;
    localparam logic [11:0] A_S1   = 12'h0A8;
    localparam logic [11:0] A_S2   = 12'h0AC;
    localparam logic [11:0] A_OTH  = 12'h010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_ram = 1'b0, bus_bitop = 1'b0;
    logic [2:0]  bus_bitpos = 3'd0;
    logic [11:0] bus_addr = 12'h000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [2:0]  spec_we;
    logic        perr;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0] we;
        logic       pe;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    prot_wr_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ram(bus_ram), .bus_bitop(bus_bitop), .bus_bitpos(bus_bitpos),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .spec_we(spec_we), .perr(perr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: one access per cycle, expectation pushed for the monitor
    task automatic acc(input logic wr, input logic rd, input logic ram, input logic bop,
                       input logic [2:0] bp, input logic [11:0] a, input logic [7:0] d,
                       input logic [2:0] ewe, input logic epe, input logic [7:0] erd,
                       input string tag);
        exp_t it;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_ram = ram; bus_bitop = bop;
        bus_bitpos = bp; bus_addr = a; bus_wdata = d;
        it.we = ewe; it.pe = epe; it.rd = erd; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic [2:0] ewe,
                      input logic epe, input string tag);
        acc(1, 0, 0, 0, 3'd0, a, d, ewe, epe, 8'h00, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic epe, input logic [7:0] erd,
                      input string tag);
        acc(0, 1, 0, 0, 3'd0, a, 8'h00, 3'b000, epe, erd, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_ram = 0; bus_bitop = 0;
        bus_bitpos = 3'd0; bus_addr = 12'h000; bus_wdata = 8'h00;
    endtask

    // monitor: strobe-cycle outputs before the edge, flag after it
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #3;
            if (q.size() != 0) begin
                it = q.pop_front();
                chk(it.tag, "spec_we", int'(spec_we), int'(it.we));
                chk(it.tag, "rd_data", int'(rd_data), int'(it.rd));
                @(posedge clk);
                #1;
                chk(it.tag, "perr", int'(perr), int'(it.pe));
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "perr after reset", int'(perr), 0);
        rd(A_STAT, 0, 8'h00, "R1");

        // R2: valid sequence to register 1
        wr(A_CMD, 8'h55, 3'b000, 0, "R2");
        wr(A_S1, 8'h12, 3'b010, 0, "R2");

        // R3: unprotected write
        wr(A_S0, 8'h34, 3'b000, 1, "R3");
        rd(A_STAT, 1, 8'h01, "R8");
        rd(A_OTH, 1, 8'h00, "R8");
        wr(A_STAT, 8'h01, 3'b000, 1, "R9");
        wr(A_STAT, 8'hFE, 3'b000, 0, "R9");

        // R4: foreign byte write then blocked special write
        wr(A_CMD, 8'h00, 3'b000, 0, "R4");
        wr(A_OTH, 8'h77, 3'b000, 1, "R4");
        wr(A_S2, 8'h01, 3'b000, 1, "R4");
        wr(A_STAT, 8'h00, 3'b000, 0, "R9");

        // R4: foreign single-bit write; R9 bit-op clears
        wr(A_CMD, 8'h00, 3'b000, 0, "R4");
        acc(1, 0, 0, 1, 3'd5, A_OTH, 8'h20, 3'b000, 1, 8'h00, "R4");
        acc(1, 0, 0, 1, 3'd3, A_STAT, 8'h00, 3'b000, 1, 8'h00, "R9");
        acc(1, 0, 0, 1, 3'd0, A_STAT, 8'h01, 3'b000, 1, 8'h00, "R9");
        acc(1, 0, 0, 1, 3'd0, A_STAT, 8'hFE, 3'b000, 0, 8'h00, "R9");

        // R5: double command write
        wr(A_CMD, 8'h00, 3'b000, 0, "R5");
        wr(A_CMD, 8'h00, 3'b000, 1, "R5");
        wr(A_S0, 8'h00, 3'b000, 1, "R5");
        wr(A_STAT, 8'h00, 3'b000, 0, "R5");

        // R6: reads and RAM accesses in the armed window
        wr(A_CMD, 8'h00, 3'b000, 0, "R6");
        rd(A_OTH, 0, 8'h00, "R6");
        rd(A_STAT, 0, 8'h00, "R6");
        acc(1, 0, 1, 0, 3'd0, A_S1, 8'h99, 3'b000, 0, 8'h00, "R6");
        acc(0, 1, 1, 0, 3'd0, A_OTH, 8'h00, 3'b000, 0, 8'h00, "R6");
        idle();
        wr(A_S0, 8'h42, 3'b001, 0, "R6");

        // R7: one special write per command
        wr(A_CMD, 8'h00, 3'b000, 0, "R7");
        wr(A_S2, 8'h01, 3'b100, 0, "R7");
        wr(A_S2, 8'h02, 3'b000, 1, "R7");

        // R10: clear beats the sequence error
        wr(A_CMD, 8'h00, 3'b000, 1, "R10");
        wr(A_STAT, 8'h00, 3'b000, 0, "R10");
        wr(A_CMD, 8'h00, 3'b000, 0, "R10");
        wr(A_STAT, 8'h01, 3'b000, 1, "R10");
        wr(A_STAT, 8'h00, 3'b000, 0, "R10");

        // R11: RAM write at a special address while idle
        acc(1, 0, 1, 0, 3'd0, A_S0, 8'hAA, 3'b000, 0, 8'h00, "R11");
        idle();
        rd(A_STAT, 0, 8'h00, "R11");
        idle();

        repeat (3) @(posedge clk);
        chk("R1", "queue drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule